// File: doc/BRIEF.md
# Acquire/Release Cache Walk Sequencer

This block sits in front of the request path of a small L1 data cache and turns memory-ordering flags into whole-cache maintenance walks. An accepted request carrying the acquire flag makes the block step through every line index and emit one invalidate command per line. A request carrying the release flag makes it emit one flush (writeback) command per line. A request carrying both flags runs the invalidate walk first and the flush walk after it. The commands leave one per clock on a valid/ready port.

The block counts outstanding flushes and invalidates. Each command it emits raises a count, and each completion pulse from the cache side lowers one. Normal issue, shown on `issue_en`, is held off while any flush is outstanding or still to be emitted. Outstanding invalidates never hold issue off. Kernel-boundary requests are still accepted while flushes are outstanding. A kernel-end request stores its context ID in a small queue, and the stored IDs come out on `kend_valid`/`kend_ctx` once the flush count is back at zero.

Top module: `ord_walk_seq`

## Requirements
- R1: An accepted plain acquire request (acquire=1, release=0, kernel=0) produces NUM_LINES commands with `cmd_flush`=0 on indices 0, 1, … NUM_LINES-1 in that order. `inv_count` rises by one for each command accepted.
- R2: An accepted plain release request produces NUM_LINES commands with `cmd_flush`=1 on ascending indices. `wb_count` rises by one for each command accepted.
- R3: A non-kernel request with both acquire and release produces the complete invalidate walk and then the complete flush walk, which is 2×NUM_LINES commands.
- R4: At most one command is transferred per clock. While `cmd_ready` is low, the pending command holds its index and kind. No request is accepted while a walk is in progress.
- R5: `issue_en` is low while `wb_count` is nonzero or a flush walk is in progress. While `wb_count` is nonzero, non-kernel requests are refused (`req_ready`=0). `issue_en` returns high when the count reaches zero.
- R6: Each `inv_done` pulse lowers `inv_count` by one. Outstanding invalidates do not lower `issue_en`.
- R7: A kernel-begin request (kernel=1, acquire=1) arriving while `wb_count` is nonzero is accepted. It starts an invalidate walk only if `inv_count` is zero, and otherwise emits no command.
- R8: A kernel-end request (kernel=1, release=1) arriving while `wb_count` is nonzero is accepted and queued without a walk. Its context is reported only after `wb_count` returns to zero.
- R9: A kernel-end request arriving while `wb_count` is zero is queued and starts a flush walk. Its context is reported once that walk's flushes have all completed.
- R10: Queued kernel-end contexts are reported in arrival order, one per clock, each with a single-cycle `kend_valid`, and only while `wb_count` is zero.
- R11: A completion pulse that arrives while its counter is zero raises `cpl_err` in the following cycle and leaves the counter at zero.
- R12: A kernel-end request is refused while the kernel-end queue holds KQ_DEPTH entries.
- R13: After reset, `cmd_valid` and `kend_valid` are low, both counts are zero, and `issue_en` and `req_ready` (for a request without flags) are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_acq | input | 1 | Request carries acquire ordering |
| req_rel | input | 1 | Request carries release ordering |
| req_kernel | input | 1 | Request is a kernel boundary (begin with acquire, end with release) |
| req_ctx | input | CTX_W | Context ID of a kernel-end request |
| req_ready | output | 1 | Request accepted this cycle if valid |
| cmd_valid | output | 1 | Maintenance command present |
| cmd_ready | input | 1 | Cache accepts the command |
| cmd_flush | output | 1 | 1 = flush/writeback, 0 = invalidate |
| cmd_index | output | IDX_W | Line index of the command |
| wb_done | input | 1 | One flush completed |
| inv_done | input | 1 | One invalidate completed |
| issue_en | output | 1 | Normal request issue allowed |
| kend_valid | output | 1 | A kernel-end completion is reported |
| kend_ctx | output | CTX_W | Context of the reported kernel end |
| wb_count | output | CNT_W | Outstanding flushes |
| inv_count | output | CNT_W | Outstanding invalidates |
| cpl_err | output | 1 | Completion arrived with its counter at zero |

## Verification
The hardest state to reach is a full kernel-end queue while flushes are still outstanding. That state needs a kernel end accepted at a zero flush count, so that it starts a walk, followed by a second kernel end accepted while the walk's flushes are unacknowledged. The bench builds this in one scenario by holding `wb_done` low after a kernel-end walk. In the same window it sends two kernel-begin requests, one with no invalidates outstanding and one with invalidates outstanding, and then offers a third kernel end that must be refused. It then releases the flush completions and watches the two contexts drain in order.

// File: rtl/ord_walk_pkg.sv
package ord_walk_pkg;
  // Kind of maintenance command sent to the cache
  typedef enum logic {
    WALK_INV   = 1'b0,
    WALK_FLUSH = 1'b1
  } walk_kind_e;
endpackage

// File: rtl/ows_walker.sv
module ows_walker
  import ord_walk_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_inv,
  input  logic             start_flush,
  output logic             busy,
  output logic             flush_pend,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output walk_kind_e       cmd_kind,
  output logic [IDX_W-1:0] cmd_index
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  logic             busy_q, busy_d;
  walk_kind_e       kind_q, kind_d;
  logic             more_q, more_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             xfer;

  assign xfer = busy_q && cmd_ready;

  always_comb begin
    busy_d = busy_q;
    kind_d = kind_q;
    more_d = more_q;
    idx_d  = idx_q;
    if (!busy_q) begin
      if (start_inv || start_flush) begin
        busy_d = 1'b1;
        idx_d  = '0;
        kind_d = start_inv ? WALK_INV : WALK_FLUSH;
        more_d = start_inv && start_flush;
      end
    end else if (xfer) begin
      if (idx_q == LAST_IDX) begin
        idx_d = '0;
        if (more_q) begin
          kind_d = WALK_FLUSH;
          more_d = 1'b0;
        end else begin
          busy_d = 1'b0;
        end
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= WALK_INV;
      more_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      kind_q <= kind_d;
      more_q <= more_d;
      idx_q  <= idx_d;
    end
  end

  assign busy       = busy_q;
  assign flush_pend = busy_q && (kind_q == WALK_FLUSH || more_q);
  assign cmd_valid  = busy_q;
  assign cmd_kind   = kind_q;
  assign cmd_index  = idx_q;
endmodule

// File: rtl/ows_counter.sv
module ows_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             err
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             bad;

  assign bad = dec && !inc && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    err_d = bad;
    if (inc && !dec)      cnt_d = cnt_q + 1'b1;
    else if (dec && !inc && !bad) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign count = cnt_q;
  assign err   = err_q;
endmodule

// File: rtl/ows_kend_fifo.sv
module ows_kend_fifo #(
  parameter int DEPTH = 4,
  parameter int CTX_W = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [CTX_W-1:0] push_ctx,
  input  logic             pop,
  output logic [CTX_W-1:0] head_ctx,
  output logic             empty,
  output logic             full
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [CTX_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    occ_d = occ_q;
    if (do_push) wr_d = (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      occ_d = occ_q + 1'b1;
    else if (do_pop && !do_push) occ_d = occ_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      occ_q <= occ_d;
    end
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  slot_q[s] <= '0;
        else if (do_push && wr_q == PTR_W'(s))       slot_q[s] <= push_ctx;
      end
    end
  endgenerate

  assign head_ctx = slot_q[rd_q];
  assign empty    = (occ_q == '0);
  assign full     = (occ_q == OCC_W'(DEPTH));
endmodule

// File: rtl/ord_walk_seq.sv
module ord_walk_seq
  import ord_walk_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int CTX_W     = 4,
  parameter int KQ_DEPTH  = 4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CNT_W = $clog2(2 * NUM_LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_acq,
  input  logic             req_rel,
  input  logic             req_kernel,
  input  logic [CTX_W-1:0] req_ctx,
  output logic             req_ready,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic             cmd_flush,
  output logic [IDX_W-1:0] cmd_index,
  input  logic             wb_done,
  input  logic             inv_done,
  output logic             issue_en,
  output logic             kend_valid,
  output logic [CTX_W-1:0] kend_ctx,
  output logic [CNT_W-1:0] wb_count,
  output logic [CNT_W-1:0] inv_count,
  output logic             cpl_err
);
  logic       walk_busy, flush_pend;
  walk_kind_e kind;
  logic       wb_zero, inv_zero, kq_full, kq_empty;
  logic       kern_end, accept;
  logic       start_inv, start_flush, kq_push, kq_pop;
  logic       xfer, wb_err, inv_err;

  assign wb_zero  = (wb_count == '0);
  assign inv_zero = (inv_count == '0);
  assign kern_end = req_kernel && req_rel;

  assign req_ready = !walk_busy && (wb_zero || req_kernel) && !(kern_end && kq_full);
  assign accept    = req_valid && req_ready;

  // Decide which walks a request starts, depending on outstanding flushes
  always_comb begin
    start_inv   = 1'b0;
    start_flush = 1'b0;
    kq_push     = 1'b0;
    if (accept) begin
      if (!wb_zero) begin
        start_inv = req_kernel && req_acq && inv_zero;
        kq_push   = kern_end;
      end else if (kern_end) begin
        kq_push     = 1'b1;
        start_flush = 1'b1;
      end else begin
        start_inv   = req_acq;
        start_flush = req_rel;
      end
    end
  end

  ows_walker #(.NUM_LINES(NUM_LINES)) u_walk (
    .clk, .rst_n,
    .start_inv, .start_flush,
    .busy(walk_busy), .flush_pend,
    .cmd_valid, .cmd_ready,
    .cmd_kind(kind), .cmd_index
  );

  assign cmd_flush = (kind == WALK_FLUSH);
  assign xfer      = cmd_valid && cmd_ready;

  ows_counter #(.CNT_W(CNT_W)) u_wb_cnt (
    .clk, .rst_n,
    .inc(xfer && cmd_flush), .dec(wb_done),
    .count(wb_count), .err(wb_err)
  );

  ows_counter #(.CNT_W(CNT_W)) u_inv_cnt (
    .clk, .rst_n,
    .inc(xfer && !cmd_flush), .dec(inv_done),
    .count(inv_count), .err(inv_err)
  );

  assign issue_en = wb_zero && !flush_pend;
  assign kq_pop   = !kq_empty && issue_en;

  ows_kend_fifo #(.DEPTH(KQ_DEPTH), .CTX_W(CTX_W)) u_kq (
    .clk, .rst_n,
    .push(kq_push), .push_ctx(req_ctx),
    .pop(kq_pop), .head_ctx(kend_ctx),
    .empty(kq_empty), .full(kq_full)
  );

  assign kend_valid = kq_pop;
  assign cpl_err    = wb_err || inv_err;
endmodule

// File: rtl/ord_walk_seq_chk.sv
module ord_walk_seq_chk #(
  parameter int IDX_W = 3,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_kernel,
  input logic             req_ready,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_flush,
  input logic [IDX_W-1:0] cmd_index,
  input logic             wb_done,
  input logic             inv_done,
  input logic             issue_en,
  input logic             kend_valid,
  input logic [CNT_W-1:0] wb_count,
  input logic [CNT_W-1:0] inv_count,
  input logic             cpl_err
);
  a_r4_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index) && $stable(cmd_flush));

  a_r4_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  a_r5_issue_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wb_count != '0 |-> !issue_en);

  a_r5_plain_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_count != '0 && req_valid && !req_kernel) |-> !req_ready);

  a_r1_inv_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_flush && !inv_done) |=> inv_count == $past(inv_count) + 1'b1);

  a_r2_wb_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_flush && !wb_done) |=> wb_count == $past(wb_count) + 1'b1);

  a_r10_kend_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    kend_valid |-> wb_count == '0);

  a_r11_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_done && wb_count == '0 && !(cmd_valid && cmd_ready && cmd_flush)) |=> cpl_err && wb_count == '0);
endmodule

bind ord_walk_seq ord_walk_seq_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk, .rst_n, .req_valid, .req_kernel, .req_ready,
  .cmd_valid, .cmd_ready, .cmd_flush, .cmd_index,
  .wb_done, .inv_done, .issue_en, .kend_valid,
  .wb_count, .inv_count, .cpl_err
);

// File: tb/ord_walk_seq_test.sv
module ord_walk_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4;
  localparam int CTXW  = 4;
  localparam int KQD   = 2;
  localparam int IDXW  = 2;
  localparam int CNTW  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_acq, req_rel, req_kernel;
  logic [CTXW-1:0] req_ctx;
  logic req_ready, cmd_valid, cmd_ready, cmd_flush;
  logic [IDXW-1:0] cmd_index;
  logic wb_done, inv_done, issue_en, kend_valid, cpl_err;
  logic [CTXW-1:0] kend_ctx;
  logic [CNTW-1:0] wb_count, inv_count;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ord_walk_seq #(.NUM_LINES(LINES), .CTX_W(CTXW), .KQ_DEPTH(KQD)) uut (
    .clk, .rst_n, .req_valid, .req_acq, .req_rel, .req_kernel, .req_ctx,
    .req_ready, .cmd_valid, .cmd_ready, .cmd_flush, .cmd_index,
    .wb_done, .inv_done, .issue_en, .kend_valid, .kend_ctx,
    .wb_count, .inv_count, .cpl_err
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // Present a request and wait until it is accepted; returns at the following negedge
  task automatic send_req(input bit acq, input bit rel, input bit kern, input int ctx);
    @(negedge clk);
    req_valid = 1'b1; req_acq = acq; req_rel = rel; req_kernel = kern;
    req_ctx = CTXW'(ctx);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_acq = 1'b0; req_rel = 1'b0; req_kernel = 1'b0;
  endtask

  // Present a request for one cycle and expect refusal
  task automatic expect_refused(input bit acq, input bit rel, input bit kern, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_acq = acq; req_rel = rel; req_kernel = kern;
    #1;
    check_eq(req, int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0; req_acq = 1'b0; req_rel = 1'b0; req_kernel = 1'b0;
  endtask

  // At a negedge right after acceptance: collect n commands of a kind, ready held high
  task automatic walk_expect(input int n, input bit flush, input string req);
    for (int i = 0; i < n; i++) begin
      check_eq({req, " valid"}, int'(cmd_valid), 1);
      check_eq({req, " index"}, int'(cmd_index), i % LINES);
      check_eq({req, " kind"}, int'(cmd_flush), int'(flush));
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_done(input bit wb, input int n);
    if (wb) wb_done = 1'b1; else inv_done = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    wb_done = 1'b0; inv_done = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 0; req_acq = 0; req_rel = 0; req_kernel = 0; req_ctx = '0;
    cmd_ready = 1'b1; wb_done = 0; inv_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b1;
    #1;
    check_eq("R13 cmd_valid", int'(cmd_valid), 0);
    check_eq("R13 kend_valid", int'(kend_valid), 0);
    check_eq("R13 wb_count", int'(wb_count), 0);
    check_eq("R13 inv_count", int'(inv_count), 0);
    check_eq("R13 issue_en", int'(issue_en), 1);
    check_eq("R13 req_ready", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_acquire();
    send_req(1, 0, 0, 0);
    walk_expect(LINES, 0, "R1 inv walk");
    check_eq("R1 walk ends", int'(cmd_valid), 0);
    check_eq("R1 inv_count", int'(inv_count), LINES);
    check_eq("R6 issue_en with inv outstanding", int'(issue_en), 1);
    check_eq("R6 wb_count untouched", int'(wb_count), 0);
    pulse_done(0, LINES);
    check_eq("R6 inv drained", int'(inv_count), 0);
    check_eq("R11 no error on valid completions", int'(cpl_err), 0);
  endtask

  task automatic t_release();
    send_req(0, 1, 0, 0);
    check_eq("R5 issue_en low during flush walk", int'(issue_en), 0);
    walk_expect(LINES, 1, "R2 flush walk");
    check_eq("R2 wb_count", int'(wb_count), LINES);
    check_eq("R2 inv_count untouched", int'(inv_count), 0);
    check_eq("R5 issue_en low", int'(issue_en), 0);
    expect_refused(0, 0, 0, "R5 plain request refused");
    pulse_done(1, LINES - 1);
    check_eq("R5 still low at one left", int'(issue_en), 0);
    pulse_done(1, 1);
    check_eq("R5 issue_en back", int'(issue_en), 1);
  endtask

  task automatic t_acq_rel();
    send_req(1, 1, 0, 0);
    walk_expect(LINES, 0, "R3 first half inv");
    walk_expect(LINES, 1, "R3 second half flush");
    check_eq("R3 walk ends", int'(cmd_valid), 0);
    check_eq("R3 wb_count", int'(wb_count), LINES);
    check_eq("R3 inv_count", int'(inv_count), LINES);
    pulse_done(1, LINES);
    pulse_done(0, LINES);
    check_eq("R3 drained", int'(wb_count) + int'(inv_count), 0);
  endtask

  task automatic t_backpressure();
    cmd_ready = 1'b0;
    send_req(1, 0, 0, 0);
    repeat (3) begin
      check_eq("R4 held valid", int'(cmd_valid), 1);
      check_eq("R4 held index", int'(cmd_index), 0);
      @(negedge clk);
    end
    expect_refused(0, 1, 0, "R4 no accept while walking");
    check_eq("R4 no transfer", int'(inv_count), 0);
    cmd_ready = 1'b1;
    walk_expect(LINES, 0, "R4 resumed walk");
    check_eq("R4 count after", int'(inv_count), LINES);
    pulse_done(0, LINES);
  endtask

  task automatic t_kernel();
    send_req(0, 1, 1, 5);
    walk_expect(LINES, 1, "R9 kernel-end walk");
    check_eq("R9 no completion yet", int'(kend_valid), 0);
    send_req(0, 1, 1, 6);
    check_eq("R8 no walk for queued kernel end", int'(cmd_valid), 0);
    check_eq("R8 wb unchanged", int'(wb_count), LINES);
    send_req(1, 0, 1, 0);
    walk_expect(LINES, 0, "R7 kernel-begin walk");
    check_eq("R7 inv_count", int'(inv_count), LINES);
    send_req(1, 0, 1, 0);
    check_eq("R7 no walk with inv outstanding", int'(cmd_valid), 0);
    check_eq("R7 inv unchanged", int'(inv_count), LINES);
    expect_refused(0, 1, 1, "R12 queue full refuses kernel end");
    check_eq("R8 still held", int'(kend_valid), 0);
    pulse_done(1, LINES);
    check_eq("R10 first valid", int'(kend_valid), 1);
    check_eq("R9 first ctx", int'(kend_ctx), 5);
    @(negedge clk);
    check_eq("R10 second valid", int'(kend_valid), 1);
    check_eq("R8 second ctx", int'(kend_ctx), 6);
    @(negedge clk);
    check_eq("R10 queue empty", int'(kend_valid), 0);
    pulse_done(0, LINES);
  endtask

  task automatic t_error();
    @(negedge clk);
    wb_done = 1'b1;
    @(negedge clk);
    wb_done = 1'b0;
    check_eq("R11 error flagged", int'(cpl_err), 1);
    check_eq("R11 count stays zero", int'(wb_count), 0);
    @(negedge clk);
    check_eq("R11 error clears", int'(cpl_err), 0);
    inv_done = 1'b1;
    @(negedge clk);
    inv_done = 1'b0;
    check_eq("R11 inv error flagged", int'(cpl_err), 1);
    check_eq("R11 inv count zero", int'(inv_count), 0);
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_release();
    t_acq_rel();
    t_backpressure();
    t_kernel();
    t_error();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule